// File: doc/BRIEF.md
# Nibble-Wide Byte Read Sequencer

This block fetches one 8-bit value from a peripheral that can only return four bits at a time on a status input. A start pulse launches a read. The block steers an external two-way, four-bit multiplexer through a control output. It waits a programmable number of clock cycles each time the multiplexer setting changes, then captures the four upper status bits. It does this once for the low half of the byte and once for the high half.

Once both halves are captured, the block joins them into a byte. It then flips bits 7 and 3, which arrive on a line whose level is inverted. The result is presented together with a one-cycle done strobe. The block then leaves the multiplexer selecting the low half, ready for the next read.

Top module: `nibble_reader`

## Requirements
- R1: After reset, `nibLoSel` is 1, `done` is 0 and `byteOut` is 0.
- R2: A start pulse while idle begins a read. `nibLoSel` stays 1 for SETTLE cycles. The low nibble is then taken from `statusIn[7:4]`.
- R3: After the low-nibble capture, `nibLoSel` is 0 for exactly SETTLE cycles. The high nibble is then taken from `statusIn[7:4]`.
- R4: The low nibble goes to `byteOut[3:0]` and the high nibble goes to `byteOut[7:4]`.
- R5: The joined value is XORed with 0x88 before it appears on `byteOut`, so bit 7 and bit 3 are inverted.
- R6: `statusIn[3:0]` has no effect on `byteOut`.
- R7: `done` is high for exactly one cycle, 2*SETTLE clock edges after the edge that accepted start. `byteOut` changes only with `done` and holds its value until the next read completes.
- R8: Start pulses that arrive while a read is in progress are ignored. They neither restart nor extend the read, and they produce no extra done.
- R9: Whenever the block is idle, including after each completed read, `nibLoSel` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request one byte read |
| statusIn | input | 8 | Status word; the multiplexer output arrives on bits 7:4 |
| nibLoSel | output | 1 | 1 selects the low nibble (the mux select pin is driven low through an external inverter); 0 selects the high nibble |
| byteOut | output | 8 | Assembled and corrected byte |
| done | output | 1 | One-cycle pulse when `byteOut` is updated |

## Verification
The bench sweeps all 256 byte values through a peripheral model that follows the multiplexer control and inverts bit 7 of each nibble. It fills the discarded low status bits with unrelated patterns. A design that swaps the nibble order, skips the 0x88 correction or reads the wrong status bits returns a wrong byte for most of the sweep. The bench counts the cycles spent in each multiplexer setting and measures the latency to done, which exposes a settle counter that is off by one. It also fires extra start pulses in the middle of reads; a design that restarts on them shows a late done or a second done.

// File: rtl/nibble_reader_pkg.sv
package nibble_reader_pkg;
  typedef struct packed {
    logic takeLo;   // capture low nibble this cycle
    logic takeHi;   // capture high nibble and publish byte
  } nibStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_LO,
    ST_WAIT_HI
  } nibState_t;
endpackage

// File: rtl/nibble_reader_ctrl.sv
module nibble_reader_ctrl
  import nibble_reader_pkg::*;
#(
  parameter int SETTLE = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output logic       nibLoSel,
  output logic       done,
  output nibStrobe_t strobe
);
  localparam int CW = $clog2(SETTLE + 1);

  nibState_t      state;
  logic [CW-1:0]  waitCnt;

  always_comb begin
    strobe.takeLo = (state == ST_WAIT_LO) && (waitCnt == '0);
    strobe.takeHi = (state == ST_WAIT_HI) && (waitCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      nibLoSel <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          nibLoSel <= 1'b1;
          if (start) begin
            state   <= ST_WAIT_LO;
            waitCnt <= CW'(SETTLE - 1);
          end
        end
        ST_WAIT_LO: begin
          if (waitCnt == '0) begin
            state    <= ST_WAIT_HI;
            waitCnt  <= CW'(SETTLE - 1);
            nibLoSel <= 1'b0;
          end else begin
            waitCnt <= waitCnt - CW'(1);
          end
        end
        ST_WAIT_HI: begin
          if (waitCnt == '0) begin
            state    <= ST_IDLE;
            nibLoSel <= 1'b1;
            done     <= 1'b1;
          end else begin
            waitCnt <= waitCnt - CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: done never lasts two cycles
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9: idle always leaves the low nibble selected
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> nibLoSel);
  // R3: high-nibble wait keeps the mux on the high inputs
  p_hi_select_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_HI) |-> !nibLoSel);
  // R8: a running wait only counts down, whatever start does
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((state != ST_IDLE) && (waitCnt != '0)) |=>
      ((state == $past(state)) && (waitCnt == $past(waitCnt) - CW'(1))));
endmodule

// File: rtl/nibble_reader_dp.sv
module nibble_reader_dp
  import nibble_reader_pkg::*;
#(
  parameter int          NIB      = 4,
  parameter logic [2*NIB-1:0] INV_MASK = 8'h88
) (
  input  logic             clk,
  input  logic             rstN,
  input  nibStrobe_t       strobe,
  input  logic [2*NIB-1:0] statusIn,
  output logic [2*NIB-1:0] byteOut
);
  localparam int BW = 2 * NIB;

  logic [NIB-1:0] loNib;
  logic [NIB-1:0] upperBits;

  assign upperBits = statusIn[BW-1:NIB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loNib   <= '0;
      byteOut <= '0;
    end else begin
      if (strobe.takeLo) loNib <= upperBits;
      if (strobe.takeHi) byteOut <= {upperBits, loNib} ^ INV_MASK;
    end
  end

  // R7: the byte moves only on a high-nibble capture
  p_byte_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.takeHi |=> $stable(byteOut));
  // R2: captures are one at a time
  p_one_take_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.takeLo && strobe.takeHi));
endmodule

// File: rtl/nibble_reader.sv
module nibble_reader
  import nibble_reader_pkg::*;
#(
  parameter int SETTLE = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] statusIn,
  output logic       nibLoSel,
  output logic [7:0] byteOut,
  output logic       done
);
  nibStrobe_t strobe;

  nibble_reader_ctrl #(.SETTLE(SETTLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .nibLoSel(nibLoSel), .done(done), .strobe(strobe)
  );

  nibble_reader_dp #(.NIB(4), .INV_MASK(8'h88)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .statusIn(statusIn), .byteOut(byteOut)
  );

  // R7: the byte only moves on the cycle done is raised
  p_byte_with_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(byteOut) |-> done);
endmodule

// File: tb/nibble_reader_tb.sv
module nibble_reader_tb;
  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] statusIn;
  logic nibLoSel, done;
  logic [7:0] byteOut;

  logic [7:0] devByte = 8'h00;
  logic [3:0] junk = 4'h0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // Peripheral: mux output on bits 7:4, bit 7 of each nibble inverted on the wire
  always_comb begin
    if (nibLoSel) statusIn = {devByte[3:0] ^ 4'b1000, junk};
    else          statusIn = {devByte[7:4] ^ 4'b1000, junk};
  end

  nibble_reader #(.SETTLE(SETTLE)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .statusIn(statusIn),
    .nibLoSel(nibLoSel), .byteOut(byteOut), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One read; optional extra start pulses mid-read
  task automatic doRead(input logic [7:0] val, input logic [3:0] lowJunk, input bit noisy);
    int lowCnt = 0;
    int hiRun = 0;
    int doneAt = 0;
    int dones = 0;
    logic [7:0] prevByte = byteOut;
    devByte = val;
    junk = lowJunk;
    @(negedge clk);
    start = 1'b1;
    for (int n = 1; n <= 2*SETTLE + 4; n++) begin
      @(negedge clk);
      start = (noisy && (n == 2 || n == SETTLE + 2)) ? 1'b1 : 1'b0;
      junk = lowJunk ^ 4'(n);
      if (!nibLoSel) lowCnt++;
      if (n <= SETTLE && !nibLoSel) hiRun++;
      if (done) begin
        dones++;
        if (doneAt == 0) doneAt = n;
      end
      if (n < 2*SETTLE + 1 && byteOut !== prevByte) hiRun++;
    end
    start = 1'b0;
    check("R2 select held low-nibble during first settle", hiRun, 0);
    check("R3 high-nibble select duration", lowCnt, SETTLE);
    check("R7 done latency", doneAt, 2*SETTLE + 1);
    check("R8 single done per read", dones, 1);
    check("R4 R5 R6 assembled byte", byteOut, val);
    check("R9 select back to low nibble", nibLoSel, 1'b1);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset select", nibLoSel, 1'b1);
    check("R1 reset done", done, 1'b0);
    check("R1 reset byte", byteOut, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    // full sweep, low status bits varied (R6), every 7th read noisy (R8)
    for (int v = 0; v < 256; v++)
      doRead(8'(v), 4'(v * 5 + 3), (v % 7) == 0);
    // R5 corner: value whose inverted bits differ only at 7 and 3
    doRead(8'h88, 4'hF, 1'b1);
    doRead(8'h00, 4'hF, 1'b0);
    // R7: byte held while idle with new peripheral data and no start
    devByte = 8'h5A;
    repeat (6) @(negedge clk);
    check("R7 byte held while idle", byteOut, 8'h00);
    check("R9 idle select", nibLoSel, 1'b1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule